// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits beside an SDRAM command issuer and decides when the memory must be refreshed. A down-counter, loaded from one of eight programmable periods measured in system clock cycles, produces periodic AUTO REFRESH requests. Software can also put the memory into self-refresh and bring it back out. While the memory is in self-refresh, periodic refresh stops and the counter is frozen.

Leaving self-refresh has two triggers. Software can write an exit code into a 3-bit command field. Alternatively, when the automatic-exit option is enabled, a pulse from the power manager that marks the end of a CPU halt causes the exit. Whichever trigger fires, the block issues one AUTO REFRESH right after the exit is accepted, clears the command field, and then resumes the periodic schedule from a freshly loaded period.

Requests leave the block on a valid/ready channel. `req_valid` rises with a request kind on `req_cmd`. Both signals hold steady until the issuer raises `req_ready`, and a request counts as accepted on a clock edge where both are high. Back-pressure never duplicates a request: at most one refresh is ever outstanding, and the interval counter waits while a request is pending. The control register, the command field and the halt-release input are plain level or strobe signals.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, `req_valid` is 0, `in_self_refresh` is 0, `cmd_rdata` reads 000 and `cfg_rdata` reads 8'h10 (automatic exit on, interval select 000, periodic refresh off).
- R2: The control register holds the periodic-refresh enable in bit 0, the interval select in bits 3:1 and the automatic-exit enable in bit 4. Bits 7:5 always read 0, whatever value was written to them.
- R3: The interval select picks a period P: 000→47, 001→78, 010→156, 011→312, 100→468, 101→624, 110→936, 111→1248. When `req_ready` is held high, consecutive periodic refresh acceptances are exactly P cycles apart. A new select value takes effect at the next counter reload.
- R4: While bit 0 is 0, no periodic refresh request is raised and the counter holds its value. After the bit is set again, periodic requests resume.
- R5: A raised request keeps `req_valid` high and `req_cmd` unchanged until it is accepted. A refresh request held off for many periods is issued once, and the next one comes P cycles after the delayed acceptance.
- R6: Writing code 101 to the command field while running issues SELF REFRESH ENTRY (`req_cmd` 01), after any outstanding refresh has been accepted. `in_self_refresh` rises when the entry is accepted, and no refresh request is raised while it is high.
- R7: Writing code 110 to the command field while in self-refresh issues SELF REFRESH EXIT (`req_cmd` 10). `in_self_refresh` falls only on acceptance of that exit.
- R8: While in self-refresh, a `halt_release` pulse issues SELF REFRESH EXIT if bit 4 is 1. The pulse is ignored if bit 4 is 0.
- R9: The request that follows an accepted exit is always AUTO REFRESH (`req_cmd` 00), even when bit 0 is 0. If bit 0 is 1, the next periodic refresh comes P cycles after this refresh is accepted.
- R10: The command field reads back the last written code. Acceptance of an exit clears it to 000.
- R11: Outside self-refresh, writing code 110 and pulsing `halt_release` have no effect: no exit is requested and `in_self_refresh` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| cmd_we | input | 1 | Command field write strobe |
| cmd_wdata | input | 3 | Command code to write |
| cmd_rdata | output | 3 | Command field read value |
| halt_release | input | 1 | One-cycle pulse marking the end of a CPU halt |
| req_valid | output | 1 | A command request is offered |
| req_ready | input | 1 | Issuer accepts the offered request |
| req_cmd | output | 2 | 00 auto refresh, 01 self-refresh entry, 10 self-refresh exit |
| in_self_refresh | output | 1 | Memory is held in self-refresh |

## Verification
A corrupted interval counter shows up as refresh acceptances whose spacing is off from P. This appears by the second acceptance after the fault, at most about 2500 cycles later. A state tracker stuck in the wrong state shows up in several ways: refresh requests appear while `in_self_refresh` is high, an exit is requested outside self-refresh, or the mandatory refresh after an exit is missing. Each of these is visible on the handshake within one or two cycles of the triggering write or pulse. A lost or doubled pending flag shows up only under back-pressure, as an acceptance one cycle after the previous one or as a request that disappears without being accepted.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

  localparam int SEL_W      = 3;
  localparam int CODE_W     = 3;
  localparam int MAX_PERIOD = 1248;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  localparam logic [CODE_W-1:0] CODE_ENTER = 3'b101;
  localparam logic [CODE_W-1:0] CODE_EXIT  = 3'b110;

  typedef enum logic [1:0] {
    RQ_REFRESH  = 2'b00,
    RQ_SR_ENTER = 2'b01,
    RQ_SR_EXIT  = 2'b10
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_SELF,
    ST_EXIT,
    ST_POST
  } seq_state_e;

  typedef struct packed {
    logic             auto_exit;
    logic [SEL_W-1:0] sel;
    logic             ar_en;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] period_states(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] p;
    case (sel)
      3'd0:    p = CNT_W'(47);
      3'd1:    p = CNT_W'(78);
      3'd2:    p = CNT_W'(156);
      3'd3:    p = CNT_W'(312);
      3'd4:    p = CNT_W'(468);
      3'd5:    p = CNT_W'(624);
      3'd6:    p = CNT_W'(936);
      default: p = CNT_W'(1248);
    endcase
    return p;
  endfunction

endpackage

// File: rtl/refresh_ctrl_reg.sv
module refresh_ctrl_reg
  import sdr_ref_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [4:0]  RESET_VAL = 5'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);

  localparam int FIELD_W = $bits(ctrl_t);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(RESET_VAL);
    end else if (we) begin
      ctrl_q <= ctrl_t'(wdata[FIELD_W-1:0]);
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = {{(DATA_W-FIELD_W){1'b0}}, ctrl_q};

endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int             CNT_W      = 11,
  parameter logic [CNT_W-1:0] RESET_LOAD = 11'd46
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             run,
  input  logic             reload,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RESET_LOAD;
    end else if (reload) begin
      cnt_q <= period - CNT_W'(1);
    end else if (run && cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign tick = run && (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/selfref_sequencer.sv
module selfref_sequencer
  import sdr_ref_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              cmd_we,
  input  logic [CODE_W-1:0] cmd_wdata,
  output logic [CODE_W-1:0] cmd_rdata,
  input  logic              halt_release,
  input  logic              tick,
  output logic              timer_run,
  output logic              timer_reload,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_cmd,
  output logic              in_sr
);

  seq_state_e        state_q;
  logic              ref_pend_q;
  logic              ent_flag_q;
  logic [CODE_W-1:0] code_q;

  logic hs;
  logic entry_wr;
  logic exit_trig;

  assign hs        = req_valid && req_ready;
  assign entry_wr  = cmd_we && (cmd_wdata == CODE_ENTER);
  assign exit_trig = (cmd_we && (cmd_wdata == CODE_EXIT)) ||
                     (halt_release && ctrl.auto_exit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      ref_pend_q <= 1'b0;
      ent_flag_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (tick) begin
            ref_pend_q <= 1'b1;
          end else if (ref_pend_q && hs) begin
            ref_pend_q <= 1'b0;
          end
          if (ent_flag_q && !ref_pend_q) begin
            state_q    <= ST_ENTER;
            ent_flag_q <= 1'b0;
          end else if (entry_wr) begin
            ent_flag_q <= 1'b1;
          end
        end
        ST_ENTER: if (hs) state_q <= ST_SELF;
        ST_SELF:  if (exit_trig) state_q <= ST_EXIT;
        ST_EXIT:  if (hs) state_q <= ST_POST;
        ST_POST:  if (hs) state_q <= ST_RUN;
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (state_q == ST_EXIT && hs) begin
      code_q <= '0;
    end else if (cmd_we) begin
      code_q <= cmd_wdata;
    end
  end

  always_comb begin
    req_valid = 1'b0;
    req_cmd   = RQ_REFRESH;
    case (state_q)
      ST_RUN:   req_valid = ref_pend_q;
      ST_ENTER: begin req_valid = 1'b1; req_cmd = RQ_SR_ENTER; end
      ST_EXIT:  begin req_valid = 1'b1; req_cmd = RQ_SR_EXIT;  end
      ST_POST:  req_valid = 1'b1;
      default:  req_valid = 1'b0;
    endcase
  end

  assign timer_run    = (state_q == ST_RUN) && ctrl.ar_en && !ent_flag_q && !ref_pend_q;
  assign timer_reload = hs && (((state_q == ST_RUN) && ref_pend_q) || (state_q == ST_POST));
  assign in_sr        = (state_q == ST_SELF) || (state_q == ST_EXIT);
  assign cmd_rdata    = code_q;

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdr_ref_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cmd_we,
  input  logic [2:0]        cmd_wdata,
  output logic [2:0]        cmd_rdata,
  input  logic              halt_release,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_cmd,
  output logic              in_self_refresh
);

  localparam logic [4:0]       CTRL_RESET = 5'h10;
  localparam logic [CNT_W-1:0] TMR_RESET  =
    period_states(CTRL_RESET[3:1]) - CNT_W'(1);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] period;
  logic             tick;
  logic             timer_run;
  logic             timer_reload;

  refresh_ctrl_reg #(
    .DATA_W   (DATA_W),
    .RESET_VAL(CTRL_RESET)
  ) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .ctrl (ctrl)
  );

  assign period = period_states(ctrl.sel);

  refresh_interval_timer #(
    .CNT_W     (CNT_W),
    .RESET_LOAD(TMR_RESET)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .period(period),
    .run   (timer_run),
    .reload(timer_reload),
    .tick  (tick)
  );

  selfref_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .cmd_we      (cmd_we),
    .cmd_wdata   (cmd_wdata),
    .cmd_rdata   (cmd_rdata),
    .halt_release(halt_release),
    .tick        (tick),
    .timer_run   (timer_run),
    .timer_reload(timer_reload),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cmd     (req_cmd),
    .in_sr       (in_self_refresh)
  );

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic [2:0] cmd_rdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_cmd,
  input logic       in_self_refresh
);

  logic exit_acc;
  logic enter_acc;
  assign exit_acc  = req_valid && req_ready && (req_cmd == 2'b10);
  assign enter_acc = req_valid && req_ready && (req_cmd == 2'b01);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_cmd)));

  assert_post_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_acc |=> (req_valid && req_cmd == 2'b00));

  assert_exit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_acc |=> (cmd_rdata == 3'b000));

  assert_leave_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_self_refresh) |-> $past(exit_acc));

  assert_enter_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_self_refresh) |-> $past(enter_acc));

  assert_no_refresh_in_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_self_refresh |-> !(req_valid && req_cmd == 2'b00));

  assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b000);

endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk u_chk (.*);

// File: tb/sim_sdram_refresh_seq.sv
module sim_sdram_refresh_seq;

  localparam int CLK_PER = 10;
  localparam int LIMIT   = 150000;
  localparam int PTAB [8] = '{47, 78, 156, 312, 468, 624, 936, 1248};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_wdata = '0;
  logic [2:0] cmd_rdata;
  logic       halt_release = 1'b0;
  logic       req_valid;
  logic       req_ready = 1'b0;
  logic [1:0] req_cmd;
  logic       in_self_refresh;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int hs_n = 0, exit_n = 0, entry_n = 0;
  int cyc_h0 = 0, cyc_h1 = 0;
  logic [1:0] cmd_h0 = '0, cmd_h1 = '0;

  always #(CLK_PER/2) clk = ~clk;

  sdram_refresh_seq u0 (.*);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && req_valid && req_ready) begin
      hs_n   <= hs_n + 1;
      cyc_h1 <= cyc_h0;
      cyc_h0 <= cyc;
      cmd_h1 <= cmd_h0;
      cmd_h0 <= req_cmd;
      if (req_cmd == 2'b10) exit_n  <= exit_n + 1;
      if (req_cmd == 2'b01) entry_n <= entry_n + 1;
    end
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(1); cfg_we = 1'b0;
  endtask

  task automatic wr_cmd(input logic [2:0] v);
    cmd_we = 1'b1; cmd_wdata = v; step(1); cmd_we = 1'b0;
  endtask

  task automatic pulse_halt();
    halt_release = 1'b1; step(1); halt_release = 1'b0;
  endtask

  task automatic wait_hs(input int target);
    while (hs_n < target) step(1);
    step(1);
  endtask

  initial begin
    int n0;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    check(req_valid == 0, "R1 valid", req_valid, 0);
    check(in_self_refresh == 0, "R1 in_sr", in_self_refresh, 0);
    check(cmd_rdata == 0, "R1 cmd field", cmd_rdata, 0);
    check(cfg_rdata == 8'h10, "R1 cfg", cfg_rdata, 8'h10);

    // R2 register layout
    wr_cfg(8'hEA);
    check(cfg_rdata == 8'h0A, "R2 readback EA", cfg_rdata, 8'h0A);
    wr_cfg(8'hFF);
    check(cfg_rdata == 8'h1F, "R2 readback FF", cfg_rdata, 8'h1F);

    // R3 interval sweep over all selects
    req_ready = 1'b1;
    for (int s = 0; s < 8; s++) begin
      wr_cfg({4'b0001, 3'(s), 1'b1});
      n0 = hs_n;
      wait_hs(n0 + 3);
      check(cyc_h0 - cyc_h1 == PTAB[s], "R3 interval", cyc_h0 - cyc_h1, PTAB[s]);
      check(cmd_h0 == 2'b00, "R3 refresh kind", cmd_h0, 0);
    end

    // R4 disable periodic refresh
    wr_cfg(8'h11);
    n0 = hs_n;
    wait_hs(n0 + 1);
    wr_cfg(8'h10);
    n0 = hs_n;
    step(2000);
    check(hs_n == n0, "R4 no refresh while disabled", hs_n - n0, 0);
    wr_cfg(8'h11);
    wait_hs(n0 + 2);
    check(cyc_h0 - cyc_h1 == 47, "R4 resumes", cyc_h0 - cyc_h1, 47);

    // R5 back-pressure
    req_ready = 1'b0;
    step(200);
    n0 = hs_n;
    check(req_valid == 1 && req_cmd == 2'b00, "R5 held request", req_valid, 1);
    req_ready = 1'b1;
    wait_hs(n0 + 2);
    check(cyc_h0 - cyc_h1 == 47, "R5 no duplicate", cyc_h0 - cyc_h1, 47);

    // R11 exit triggers outside self-refresh
    wr_cfg(8'h10);
    step(5);
    wr_cmd(3'b110);
    pulse_halt();
    step(100);
    check(exit_n == 0, "R11 no exit request", exit_n, 0);
    check(in_self_refresh == 0, "R11 in_sr", in_self_refresh, 0);
    check(cmd_rdata == 3'b110, "R10 readback", cmd_rdata, 6);

    // R6 entry
    wr_cfg(8'h11);
    wr_cmd(3'b101);
    while (entry_n < 1) step(1);
    step(1);
    check(in_self_refresh == 1, "R6 in_sr", in_self_refresh, 1);
    check(cmd_rdata == 3'b101, "R10 entry code", cmd_rdata, 5);
    n0 = hs_n;
    step(3000);
    check(hs_n == n0, "R6 no refresh in SR", hs_n - n0, 0);

    // R8 auto exit disabled then enabled
    wr_cfg(8'h01);
    pulse_halt();
    step(100);
    check(in_self_refresh == 1 && exit_n == 0, "R8 ignored", exit_n, 0);
    wr_cfg(8'h11);
    n0 = hs_n;
    pulse_halt();
    wait_hs(n0 + 2);
    check(cmd_h1 == 2'b10 && cmd_h0 == 2'b00, "R9 refresh after exit", cmd_h0, 0);
    check(cyc_h0 - cyc_h1 == 1, "R9 immediate", cyc_h0 - cyc_h1, 1);
    check(in_self_refresh == 0, "R8 left SR", in_self_refresh, 0);
    check(cmd_rdata == 0, "R10 cleared", cmd_rdata, 0);
    wait_hs(n0 + 3);
    check(cyc_h0 - cyc_h1 == 47, "R9 periodic resumes", cyc_h0 - cyc_h1, 47);

    // R7 commanded exit with periodic refresh off
    wr_cmd(3'b101);
    while (entry_n < 2) step(1);
    wr_cfg(8'h00);
    step(10);
    n0 = hs_n;
    wr_cmd(3'b110);
    wait_hs(n0 + 2);
    check(exit_n == 2, "R7 exit issued", exit_n, 2);
    check(cmd_h0 == 2'b00, "R9 refresh with enable off", cmd_h0, 0);
    check(in_self_refresh == 0, "R7 left SR", in_self_refresh, 0);
    check(cmd_rdata == 0, "R10 cleared again", cmd_rdata, 0);
    n0 = hs_n;
    step(500);
    check(hs_n == n0, "R4 stays quiet", hs_n - n0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule